// File: doc/BRIEF.md
# Mouse Motion Packet Encoder

This block converts pointing-device events into fixed five-byte packets and stores them in a byte queue. A host drains the queue one byte per read strobe. An event carries signed X and Y deltas wider than a byte and three button levels. The block clamps both deltas into a symmetric 8-bit range and flips the sign of Y. It forms a header byte whose low three bits are active-low button flags, and it appends two zero bytes after the motion bytes.

Each accepted event produces five queue writes on five consecutive clock cycles. An event that arrives while a packet is still being written waits in a single holding slot. That slot is taken up in the same cycle the current packet finishes, so back-to-back packets have no idle cycle between them. The queue is circular. A byte offered to a full queue is lost. When the queue is empty the head output reads as zero.

Top module: `mouse_pkt_encoder`

## Requirements
- R1: During and after reset the queue is empty: `count_o` is 0, `avail_o` is 0 and `head_o` is 0x00.
- R2: Packet byte 0 is 0x87 with bit 2 cleared when the left button is pressed, bit 1 cleared when the middle button is pressed and bit 0 cleared when the right button is pressed. All 8 combinations follow this rule.
- R3: Packet byte 1 is the X delta saturated to the range -127..+127, in 8-bit two's complement. Any X of 128 or more gives 0x7F. Any X of -128 or less, -128 itself included, gives 0x81.
- R4: Packet byte 2 is the negated Y delta, saturated the same way. Y = -32768 gives 0x7F, Y = 127 gives 0x81 and Y = -128 gives 0x7F.
- R5: Packet bytes 3 and 4 are always 0x00.
- R6: If `evt_i` is sampled high at edge E while the block is idle, the five bytes enter the queue in order at edges E+1 through E+5. With an empty queue and no reads, `count_o` therefore steps 1,2,3,4,5 after those edges.
- R7: An event sampled while a packet is still being written (before its last byte) is held in one slot. A later held event replaces an earlier one. The held packet starts at the edge that writes the last byte of the current packet.
- R8: The queue holds 256 bytes. A byte offered when `count_o` is 256 is discarded, even if a read happens in the same cycle.
- R9: `rd_i` while `count_o` is nonzero removes the head byte. `rd_i` on an empty queue changes nothing. `avail_o` is high exactly when `count_o` is nonzero. `head_o` shows the oldest byte, or 0x00 when empty.
- R10: A write and a read in the same cycle on a queue that is neither empty nor full leave `count_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| evt_i | input | 1 | Event strobe, one cycle per event |
| dx_i | input | 16 | Signed X delta |
| dy_i | input | 16 | Signed Y delta |
| btn_l_i | input | 1 | Left button pressed |
| btn_m_i | input | 1 | Middle button pressed |
| btn_r_i | input | 1 | Right button pressed |
| rd_i | input | 1 | Pop the head byte |
| head_o | output | 8 | Oldest queued byte, 0x00 when empty |
| avail_o | output | 1 | Queue not empty |
| count_o | output | 9 | Number of bytes queued |

## Verification
Clamping is tested at 127/128, at -127/-128 and at the extreme 16-bit values on both axes. A design that clamped before negating Y, or that let -128 through, would queue 0x80 or the wrong sign. Events are fired on every cycle, so the holding slot is overwritten and the handoff with no gap is exercised. A sequencer that dropped, duplicated or delayed a packet would shift every later byte. The queue is overfilled and then drained past empty to expose a wrong full test, pointer wrap or count. Reads and writes are also mixed on a full queue, where a design that checked space after the pop would accept a byte it must drop.

// File: rtl/mouse_pkt_pkg.sv
`timescale 1ns/1ps
package mouse_pkt_pkg;
    localparam int PKT_LEN = 5;
    localparam int IDX_W   = $clog2(PKT_LEN);
    localparam logic [7:0] HDR_BASE = 8'h87;

    // byte 0 is sent first
    typedef logic [PKT_LEN-1:0][7:0] pkt_t;
endpackage

// File: rtl/mouse_pkt_build.sv
`timescale 1ns/1ps
module mouse_pkt_build
    import mouse_pkt_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0] dx_i,
    input  logic [DW-1:0] dy_i,
    input  logic          btn_l_i,
    input  logic          btn_m_i,
    input  logic          btn_r_i,
    output pkt_t          pkt_o
);
    localparam int EW = DW + 1;
    localparam logic signed [EW-1:0] LIM_P = EW'(127);
    localparam logic signed [EW-1:0] LIM_N = -LIM_P;

    logic signed [EW-1:0] x_ext;
    logic signed [EW-1:0] y_neg;

    function automatic logic [7:0] sat8(input logic signed [EW-1:0] v);
        if (v > LIM_P)      return 8'h7f;
        else if (v < LIM_N) return 8'h81;
        else                return v[7:0];
    endfunction

    always_comb begin
        x_ext = {dx_i[DW-1], dx_i};
        // negate in the widened domain so the most negative input survives
        y_neg = -$signed({dy_i[DW-1], dy_i});
        pkt_o    = '0;
        pkt_o[0] = HDR_BASE ^ {5'b0, btn_l_i, btn_m_i, btn_r_i};
        pkt_o[1] = sat8(x_ext);
        pkt_o[2] = sat8(y_neg);
    end
endmodule

// File: rtl/mouse_pkt_seq.sv
`timescale 1ns/1ps
module mouse_pkt_seq
    import mouse_pkt_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       evt_i,
    input  pkt_t       pkt_i,
    output logic       push_o,
    output logic [7:0] push_byte_o
);
    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
        pkt_t             pkt;
        logic             pend;
        pkt_t             pend_pkt;
    } seq_t;

    seq_t s_d, s_q;
    logic last, free;

    always_comb begin
        s_d  = s_q;
        last = s_q.busy && (s_q.idx == IDX_W'(PKT_LEN - 1));
        free = !s_q.busy || last;
        if (s_q.busy && !last) s_d.idx = s_q.idx + 1'b1;
        if (free) begin
            s_d.idx = '0;
            if (s_q.pend) begin
                s_d.busy = 1'b1;
                s_d.pkt  = s_q.pend_pkt;
                s_d.pend = evt_i;
                if (evt_i) s_d.pend_pkt = pkt_i;
            end else if (evt_i) begin
                s_d.busy = 1'b1;
                s_d.pkt  = pkt_i;
            end else begin
                s_d.busy = 1'b0;
            end
        end else if (evt_i) begin
            s_d.pend     = 1'b1;
            s_d.pend_pkt = pkt_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign push_o      = s_q.busy;
    assign push_byte_o = s_q.pkt[s_q.idx];

    // R7
    hold_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_i && s_q.busy && !last) |=> s_q.pend);

    // R6
    burst_cont_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.busy && !last) |=> (s_q.busy && s_q.idx == $past(s_q.idx) + 1'b1));
endmodule

// File: rtl/byte_ring.sv
`timescale 1ns/1ps
module byte_ring #(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          push_i,
    input  logic [7:0]    byte_i,
    input  logic          pop_i,
    output logic [7:0]    head_o,
    output logic [CW-1:0] count_o
);
    typedef struct packed {
        logic [AW-1:0] rptr;
        logic [AW-1:0] wptr;
        logic [CW-1:0] cnt;
    } ring_t;

    ring_t r_d, r_q;
    logic [7:0] mem [DEPTH];
    logic push_ok, pop_ok;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        r_d     = r_q;
        push_ok = push_i && (r_q.cnt < CW'(DEPTH));
        pop_ok  = pop_i && (r_q.cnt != '0);
        if (push_ok) r_d.wptr = bump(r_q.wptr);
        if (pop_ok)  r_d.rptr = bump(r_q.rptr);
        r_d.cnt = r_q.cnt + CW'(push_ok) - CW'(pop_ok);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    always_ff @(posedge clk_i) begin
        if (push_ok) mem[r_q.wptr] <= byte_i;
    end

    assign head_o  = (r_q.cnt != '0) ? mem[r_q.rptr] : 8'h00;
    assign count_o = r_q.cnt;

    // R8
    full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && !pop_i && count_o == CW'(DEPTH)) |=> count_o == CW'(DEPTH));

    // R9
    empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pop_i && !push_i && count_o == '0) |=> count_o == '0);

    // R10
    pass_thru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && pop_i && count_o != '0 && count_o != CW'(DEPTH)) |=> $stable(count_o));
endmodule

// File: rtl/mouse_pkt_encoder.sv
`timescale 1ns/1ps
module mouse_pkt_encoder
    import mouse_pkt_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 256,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          evt_i,
    input  logic [DW-1:0] dx_i,
    input  logic [DW-1:0] dy_i,
    input  logic          btn_l_i,
    input  logic          btn_m_i,
    input  logic          btn_r_i,
    input  logic          rd_i,
    output logic [7:0]    head_o,
    output logic          avail_o,
    output logic [CW-1:0] count_o
);
    pkt_t       new_pkt;
    logic       push;
    logic [7:0] push_byte;

    mouse_pkt_build #(.DW(DW)) u_build (
        .dx_i(dx_i), .dy_i(dy_i),
        .btn_l_i(btn_l_i), .btn_m_i(btn_m_i), .btn_r_i(btn_r_i),
        .pkt_o(new_pkt)
    );

    mouse_pkt_seq u_seq (
        .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .pkt_i(new_pkt),
        .push_o(push), .push_byte_o(push_byte)
    );

    byte_ring #(.DEPTH(DEPTH), .CW(CW)) u_ring (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .push_i(push), .byte_i(push_byte), .pop_i(rd_i),
        .head_o(head_o), .count_o(count_o)
    );

    assign avail_o = (count_o != '0);

    // R1
    reset_empty_chk: assert property (@(posedge clk_i)
        !rst_ni |=> (count_o == '0));
endmodule

// File: tb/test_mouse_pkt_encoder.sv
`timescale 1ns/1ps
module test_mouse_pkt_encoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt = 1'b0;
    logic [15:0] dx = '0, dy = '0;
    logic        bl = 1'b0, bm = 1'b0, br = 1'b0;
    logic        rd = 1'b0;
    logic [7:0]  head;
    logic        avail;
    logic [8:0]  count;

    int n_vec = 0, n_bad = 0;
    string ph = "R1";

    always #2 clk = ~clk;

    mouse_pkt_encoder i_mouse_pkt_encoder (
        .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .dx_i(dx), .dy_i(dy),
        .btn_l_i(bl), .btn_m_i(bm), .btn_r_i(br), .rd_i(rd),
        .head_o(head), .avail_o(avail), .count_o(count)
    );

    // behavioural reference
    logic [7:0] mq[$];
    bit         m_busy, m_pend;
    int         m_idx;
    logic [7:0] m_pkt[5], m_ppkt[5];

    function automatic logic [7:0] sat(input int v);
        int c;
        c = (v > 127) ? 127 : (v < -127) ? -127 : v;
        return c[7:0];
    endfunction

    task automatic enc(output logic [7:0] p[5]);
        p[0] = 8'h87;
        if (bl) p[0][2] = 1'b0;
        if (bm) p[0][1] = 1'b0;
        if (br) p[0][0] = 1'b0;
        p[1] = sat(int'($signed(dx)));
        p[2] = sat(-int'($signed(dy)));
        p[3] = 8'h00;
        p[4] = 8'h00;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete(); m_busy = 0; m_pend = 0; m_idx = 0;
        end else begin
            int  sz;
            bit  fin;
            logic [7:0] np[5];
            sz = mq.size();
            enc(np);
            if (rd && sz > 0) void'(mq.pop_front());
            if (m_busy && sz < 256) mq.push_back(m_pkt[m_idx]);
            fin = m_busy && m_idx == 4;
            if (!m_busy || fin) begin
                m_idx = 0;
                if (m_pend) begin
                    m_pkt = m_ppkt; m_busy = 1;
                    m_pend = evt;
                    if (evt) m_ppkt = np;
                end else if (evt) begin
                    m_pkt = np; m_busy = 1;
                end else m_busy = 0;
            end else begin
                m_idx++;
                if (evt) begin m_pend = 1; m_ppkt = np; end
            end
        end
    end

    task automatic compare();
        logic [7:0] eh;
        int es;
        es = mq.size();
        eh = (es > 0) ? mq[0] : 8'h00;
        n_vec++;
        if (head !== eh || avail !== (es != 0) || count !== 9'(es)) begin
            n_bad++;
            $display("FAIL %s: head=%h avail=%b count=%0d expected head=%h avail=%b count=%0d",
                     ph, head, avail, count, eh, es != 0, es);
        end
    endtask

    task automatic step(input bit e, input int x, input int y,
                        input bit l, input bit m, input bit r, input bit rdv);
        @(negedge clk);
        compare();
        evt = e; dx = 16'(x); dy = 16'(y); bl = l; bm = m; br = r; rd = rdv;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic drain();
        for (int i = 0; i < 300; i++) step(0, 0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic expect_count(input int c);
        n_vec++;
        if (count !== 9'(c)) begin
            n_bad++;
            $display("FAIL R6: count=%0d expected %0d", count, c);
        end
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int xs[10] = '{0, 1, -1, 127, 128, -127, -128, 32767, -32768, 300};
        // R1 reset state
        ph = "R1";
        repeat (3) step(0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        idle(2);

        // R6 cycle timing of a single packet
        ph = "R6";
        step(1, 5, -3, 0, 0, 0, 0);
        for (int k = 0; k <= 5; k++) begin
            step(0, 0, 0, 0, 0, 0, 0);
            expect_count(k);
        end
        drain();

        // R2 all button combinations
        ph = "R2";
        for (int b = 0; b < 8; b++) begin
            step(1, 2, 2, b[2], b[1], b[0], 0);
            idle(6);
            drain();
        end

        // R3 X saturation, R5 trailing zeros
        ph = "R3";
        foreach (xs[i]) begin
            step(1, xs[i], 0, 0, 0, 0, 0);
            idle(6);
            drain();
        end
        ph = "R5";
        step(1, 9, 9, 1, 1, 1, 0); idle(6); drain();

        // R4 Y negation then saturation
        ph = "R4";
        foreach (xs[i]) begin
            step(1, 0, xs[i], 0, 0, 0, 0);
            idle(6);
            drain();
        end

        // R7 events every cycle overwrite the holding slot
        ph = "R7";
        for (int i = 0; i < 23; i++) step(1, i * 11 - 120, 60 - i * 7, i[0], i[1], i[2], 0);
        idle(12);
        drain();

        // R8 overfill then drain past empty
        ph = "R8";
        for (int i = 0; i < 70; i++) begin
            step(1, i * 3, -i * 5, i[1], 0, i[0], 0);
            idle(4);
        end
        idle(10);
        for (int i = 0; i < 40; i++) step(1, i, i, 0, 1, 0, 1);
        idle(10);
        drain();

        // R9 read on empty
        ph = "R9";
        for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0, 0, 1);

        // R10 mixed traffic with concurrent pushes and pops
        ph = "R10";
        for (int i = 0; i < 4000; i++) begin
            int x, y;
            x = ($urandom_range(0, 3) == 0) ? xs[$urandom_range(0, 9)] : $urandom_range(0, 400) - 200;
            y = ($urandom_range(0, 3) == 0) ? xs[$urandom_range(0, 9)] : $urandom_range(0, 400) - 200;
            step($urandom_range(0, 3) == 0, x, y, $urandom_range(0, 1), $urandom_range(0, 1),
                 $urandom_range(0, 1), (i % 1000 < 500) ? $urandom_range(0, 3) == 0 : $urandom_range(0, 1));
        end
        idle(10);
        drain();

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule